// File: doc/BRIEF.md
# Multi-channel conversion rate scheduler

This block sets the timing of conversion slots for an eight-channel resistance temperature front end. Each slot starts with a one-cycle strobe and a code for the slot type. The converter downstream acts on the strobe. The scheduler only decides when a slot starts, what kind of slot it is and how long it lasts.

Time is counted in base ticks of 1/300 s. Each tick is `TICK_CYC` clock cycles. Slot lengths in ticks are:

- Normal slot: 15 ticks with 60 Hz mains (20 updates per second), 18 ticks with 50 Hz mains (about 16.67 per second).
- Lead-resistance slot: 150 ticks at 60 Hz, 100 ticks at 50 Hz.
- Calibration slot: 300 ticks.

A free-running period of 1935 ticks (6.45 s) makes a lead-resistance slot due, but only if at least one channel is wired three-wire. A calibration slot runs once per request. A request that arrives while another slot is running waits until that slot ends. The mains select is read only when a slot starts.

Top module: `conv_slot_sched`

## Requirements
- R1: With `sel_50hz`=0 when a normal slot starts, that slot lasts 15*TICK_CYC cycles, measured from its strobe to the next strobe.
- R2: With `sel_50hz`=1 when a normal slot starts, that slot lasts 18*TICK_CYC cycles.
- R3: A lead period counter runs from reset release and wraps every 1935*TICK_CYC cycles. At each wrap, a lead-resistance slot becomes due if `wire4_mask` has at least one 0 bit. Bit i is channel i; 0 means three-wire and 1 means four-wire. The due slot is issued at the next slot start, provided the mask still has a 0 bit then. Otherwise it is dropped.
- R4: A lead-resistance slot (code 1) lasts 150*TICK_CYC cycles if `sel_50hz`=0 at its start, and 100*TICK_CYC cycles if `sel_50hz`=1.
- R5: A `cal_req` pulse makes one calibration slot (code 2) pending. That slot lasts 300*TICK_CYC cycles. Pulses that arrive before the pending slot starts merge into it. A pulse that arrives during a calibration slot makes one new slot pending.
- R6: A calibration request that arrives during a lead-resistance slot waits for that slot to end. When a lead slot and a calibration slot are both pending at a slot start, the lead slot goes first and the calibration slot follows it.
- R7: While every mask bit is 1 (all four-wire), no lead-resistance slot is issued.
- R8: Changing `sel_50hz` in the middle of a slot does not change that slot's length. Only the next slot start reads the new value.
- R9: `slot_kind` is 0 for normal, 1 for lead-resistance and 2 for calibration. It is held for the whole slot. `busy` is 1 exactly during lead-resistance and calibration slots.
- R10: During reset, `conv_strobe`, `slot_kind` and `busy` are 0. The first strobe, a normal slot, appears in the cycle after the first rising edge at which reset is released. Each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_50hz | input | 1 | Mains select: 1 = 50 Hz, 0 = 60 Hz |
| wire4_mask | input | 8 | Wire mode per channel: bit i = channel i, 1 = four-wire, 0 = three-wire |
| cal_req | input | 1 | One-cycle self-calibration request |
| conv_strobe | output | 1 | One-cycle pulse at the start of each slot |
| slot_kind | output | 2 | Type of the current slot: 0 normal, 1 lead-resistance, 2 calibration |
| busy | output | 1 | High during a lead-resistance or calibration slot |

## Verification
The bench builds the block with `TICK_CYC`=2, so a lead period is 3870 cycles and a calibration slot is 600 cycles. At that scale a single run covers many lead periods and calibration cycles. It also covers many changes of the mains select, including select changes that land close to slot starts and calibration pulses that land inside lead slots. With a prescaler other than 1, a slot length that was not multiplied by the prescaler would show up as a wrong slot length.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  typedef enum logic [1:0] {
    SLOT_NORM = 2'd0,
    SLOT_LEAD = 2'd1,
    SLOT_CAL  = 2'd2
  } slot_kind_e;

  // slot lengths in base ticks of 1/300 s
  localparam int unsigned NORM60_TK   = 15;
  localparam int unsigned NORM50_TK   = 18;
  localparam int unsigned LEAD60_TK   = 150;
  localparam int unsigned LEAD50_TK   = 100;
  localparam int unsigned CAL_TK      = 300;
  localparam int unsigned LEAD_PER_TK = 1935;

  function automatic int unsigned slot_ticks(slot_kind_e kind, logic sel50);
    int unsigned t;
    case (kind)
      SLOT_LEAD: t = sel50 ? LEAD50_TK : LEAD60_TK;
      SLOT_CAL:  t = CAL_TK;
      default:   t = sel50 ? NORM50_TK : NORM60_TK;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sched_lead_timer.sv
module sched_lead_timer #(
  parameter int unsigned PER_CYC = 1935,
  parameter int unsigned N_CH    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] wire4_mask,
  input  logic            slot_end,
  output logic            any3w,
  output logic            lead_expire,
  output logic            lead_due
);
  localparam int unsigned TW = $clog2(PER_CYC + 1);

  logic [TW-1:0] tmr_q;

  assign any3w       = ~(&wire4_mask);
  assign lead_expire = (tmr_q == TW'(PER_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      lead_due <= 1'b0;
    end else begin
      tmr_q    <= lead_expire ? '0 : tmr_q + 1'b1;
      lead_due <= (lead_expire & any3w) | (lead_due & ~slot_end);
    end
  end
endmodule

// File: rtl/sched_cal_latch.sv
module sched_cal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic take_cal,
  output logic cal_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_pend <= 1'b0;
    else        cal_pend <= (cal_pend & ~take_cal) | cal_req;
  end
endmodule

// File: rtl/sched_slot_seq.sv
module sched_slot_seq
  import conv_sched_pkg::*;
#(
  parameter int unsigned TICK_CYC = 160000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_50hz,
  input  logic       lead_due,
  input  logic       any3w,
  input  logic       cal_pend,
  output logic       slot_end,
  output logic       take_lead,
  output logic       take_cal,
  output logic       conv_strobe,
  output logic [1:0] slot_kind,
  output logic       busy
);
  localparam int unsigned MAX_CYC = CAL_TK * TICK_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          first_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_q;
  slot_kind_e    next_kind;
  logic [CW-1:0] next_len;

  assign slot_end  = first_q | (cnt_q == len_q - 1'b1);
  assign take_lead = slot_end & lead_due & any3w;
  assign take_cal  = slot_end & ~take_lead & cal_pend;

  always_comb begin
    if (take_lead)     next_kind = SLOT_LEAD;
    else if (take_cal) next_kind = SLOT_CAL;
    else               next_kind = SLOT_NORM;
    next_len = CW'(slot_ticks(next_kind, sel_50hz) * TICK_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= 1'b1;
      cnt_q       <= '0;
      len_q       <= '1;
      conv_strobe <= 1'b0;
      slot_kind   <= SLOT_NORM;
      busy        <= 1'b0;
    end else if (slot_end) begin
      first_q     <= 1'b0;
      cnt_q       <= '0;
      len_q       <= next_len;
      conv_strobe <= 1'b1;
      slot_kind   <= next_kind;
      busy        <= (next_kind != SLOT_NORM);
    end else begin
      cnt_q       <= cnt_q + 1'b1;
      conv_strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_slot_sched.sv
module conv_slot_sched
  import conv_sched_pkg::*;
#(
  parameter int unsigned TICK_CYC = 160000,
  parameter int unsigned N_CH     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_50hz,
  input  logic [N_CH-1:0] wire4_mask,
  input  logic            cal_req,
  output logic            conv_strobe,
  output logic [1:0]      slot_kind,
  output logic            busy
);
  localparam int unsigned LEAD_PER_CYC = LEAD_PER_TK * TICK_CYC;

  logic slot_end, take_lead, take_cal;
  logic any3w, lead_expire, lead_due, cal_pend;

  sched_lead_timer #(.PER_CYC(LEAD_PER_CYC), .N_CH(N_CH)) lead_i (
    .clk(clk), .rst_n(rst_n), .wire4_mask(wire4_mask), .slot_end(slot_end),
    .any3w(any3w), .lead_expire(lead_expire), .lead_due(lead_due)
  );

  sched_cal_latch cal_i (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .take_cal(take_cal),
    .cal_pend(cal_pend)
  );

  sched_slot_seq #(.TICK_CYC(TICK_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .sel_50hz(sel_50hz), .lead_due(lead_due),
    .any3w(any3w), .cal_pend(cal_pend), .slot_end(slot_end),
    .take_lead(take_lead), .take_cal(take_cal), .conv_strobe(conv_strobe),
    .slot_kind(slot_kind), .busy(busy)
  );
endmodule

// File: rtl/conv_slot_sched_chk.sv
module conv_slot_sched_chk
  import conv_sched_pkg::*;
#(
  parameter int unsigned TICK_CYC = 160000,
  parameter int unsigned N_CH     = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_50hz,
  input logic [N_CH-1:0] wire4_mask,
  input logic            conv_strobe,
  input logic [1:0]      slot_kind,
  input logic            cal_pend
);
  int unsigned gap_q, exp_q;
  logic        seen_q, sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      exp_q  <= 0;
      seen_q <= 1'b0;
      sel_d  <= 1'b0;
    end else begin
      sel_d <= sel_50hz;
      if (conv_strobe) begin
        gap_q  <= 1;
        exp_q  <= slot_ticks(slot_kind_e'(slot_kind), sel_d) * TICK_CYC;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1;
      end
    end
  end

  AST_SLOT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && seen_q) |-> (gap_q == exp_q)); // R1

  AST_NO_LEAD_ALL4W: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && slot_kind == SLOT_LEAD) |-> ($past(wire4_mask) != '1)); // R7

  AST_CAL_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && slot_kind == SLOT_CAL) |-> $past(cal_pend)); // R5

  AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_strobe |-> $stable(slot_kind)); // R9

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    slot_kind != 2'd3); // R9
endmodule

bind conv_slot_sched conv_slot_sched_chk #(.TICK_CYC(TICK_CYC), .N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_50hz(sel_50hz), .wire4_mask(wire4_mask),
  .conv_strobe(conv_strobe), .slot_kind(slot_kind), .cal_pend(cal_pend)
);

// File: tb/conv_slot_sched_tb_top.sv
module conv_slot_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TCYC       = 2;
  localparam int LEADC      = 1935 * TCYC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_50hz = 1'b0;
  logic [7:0] wire4_mask = 8'hFF;
  logic       cal_req = 1'b0;
  logic       conv_strobe, busy;
  logic [1:0] slot_kind;

  int total = 0, bad = 0, cyc = 0, lead_seen = 0, cal_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_slot_sched #(.TICK_CYC(TCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_50hz(sel_50hz), .wire4_mask(wire4_mask),
    .cal_req(cal_req), .conv_strobe(conv_strobe), .slot_kind(slot_kind), .busy(busy)
  );

  function automatic int exp_cycles(int kind, bit s50);
    if (kind == 2) return 300 * TCYC;
    if (kind == 1) return (s50 ? 100 : 150) * TCYC;
    return (s50 ? 18 : 15) * TCYC;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  // reference model: advanced on each rising edge, using the requirements
  bit m_first = 1, m_strobe = 0, m_busy = 0, m_due = 0, m_pend = 0, m_sel = 0;
  int m_kind = 0, m_cnt = 0, m_len = 1, m_lt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_first = 1; m_strobe = 0; m_busy = 0; m_due = 0; m_pend = 0;
      m_kind = 0; m_cnt = 0; m_len = 1; m_lt = 0;
    end else begin
      bit bnd, wrap, three, tl, tc;
      bnd   = m_first || (m_cnt == m_len - 1);
      wrap  = (m_lt == LEADC - 1);
      three = (wire4_mask != 8'hFF);
      tl    = bnd && m_due && three;
      tc    = bnd && !tl && m_pend;
      if (bnd) begin
        m_kind = tl ? 1 : (tc ? 2 : 0);
        m_sel  = sel_50hz;
        m_len  = exp_cycles(m_kind, sel_50hz);
        m_cnt = 0; m_strobe = 1; m_first = 0; m_busy = (m_kind != 0);
      end else begin
        m_cnt++; m_strobe = 0;
      end
      m_due  = (wrap && three) || (m_due && !bnd);
      m_pend = (m_pend && !tc) || cal_req;
      m_lt   = wrap ? 0 : m_lt + 1;
    end
  end

  function automatic string tag_of();
    if (!m_strobe) return "R8";
    if (m_kind == 1) return "R4";
    if (m_kind == 2) return "R5";
    return m_sel ? "R2" : "R1";
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(conv_strobe == m_strobe, tag_of(), conv_strobe, m_strobe, "strobe");
      chk(slot_kind == m_kind[1:0], "R9", slot_kind, m_kind, "slot_kind");
      chk(busy == m_busy, "R9", busy, m_busy, "busy");
      if (conv_strobe && slot_kind == 2'd1) lead_seen++;
      if (conv_strobe && slot_kind == 2'd2) cal_seen++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic wait_strobe(int kind, int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (conv_strobe && slot_kind == kind[1:0]) got = 1;
    end
  endtask

  initial begin
    bit got;
    int l0, c0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(conv_strobe == 0 && slot_kind == 0 && busy == 0, "R10", {conv_strobe, slot_kind, busy}, 0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk(conv_strobe == 1, "R10", conv_strobe, 1, "first strobe");
    chk(slot_kind == 0, "R10", slot_kind, 0, "first slot normal");

    // all four-wire: no lead slots over more than two lead periods
    l0 = lead_seen;
    repeat (2 * LEADC + 500) @(negedge clk);
    chk(lead_seen == l0, "R7", lead_seen - l0, 0, "lead slots with all four-wire");

    // one three-wire channel: lead slots appear
    wire4_mask = 8'hFB;
    wait_strobe(1, LEADC + 1000, got);
    chk(got, "R3", got, 1, "lead slot with three-wire channel");

    // calibration request inside lead slot waits, runs right after
    @(negedge clk); cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
    chk(busy == 1 && slot_kind == 1, "R6", slot_kind, 1, "lead slot still running");
    wait_strobe(2, 1000, got);
    chk(got, "R6", got, 1, "pending calibration follows lead");

    // mains select toggled mid-slot and at random
    for (int k = 0; k < 40; k++) begin
      repeat (5 + ($urandom % 60)) @(negedge clk);
      sel_50hz = ~sel_50hz;
    end

    // random phase
    c0 = cal_seen;
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom % 100;
      if (r < 10) sel_50hz = $urandom % 2;
      if (r >= 10 && r < 14) wire4_mask = ($urandom % 2) ? 8'hFF : 8'($urandom);
      if (r >= 14 && r < 18) begin cal_req = 1'b1; @(negedge clk); cal_req = 1'b0; end
      repeat (20 + ($urandom % 200)) @(negedge clk);
    end
    chk(cal_seen > c0, "R5", cal_seen - c0, 1, "calibration slots in random phase");
    repeat (700) @(negedge clk);
    finish_run();
  end
endmodule